// File: doc/BRIEF.md
# Timestamp Pulse-Width Qualifier

Five timestamp sources feed this block, one per input channel. All five count on a single shared time base, so stamps from different channels can be compared directly. Each source reports edge events, rising or falling. Each event carries a timestamp made of a coarse count of 8 ns clock cycles and a fine bin count with 81 ps per bin. For every channel the block keeps the most recent rising stamp. When the matching falling stamp arrives, the block computes the pulse width by subtracting the two stamps at full bin precision. Only the rising stamp of a pulse at least 100 ns wide is passed on. Falling stamps never leave the block.

A rising edge is also refused when it comes too soon after the previous accepted rising edge on the same channel. Such refusals are counted per channel. A second rising edge that arrives while a stamp is still waiting for its falling edge replaces the waiting stamp and is counted as an overlap. Qualified stamps wait in a small per-channel buffer. A round-robin arbiter merges the five buffers onto one valid/ready stream and tags each stamp with its channel number.

Top module: `pulse_width_qualifier`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, every overlap and spacing counter reads 0, and every overflow flag is 0. All waiting stamps, spacing history and buffered stamps are cleared.
- R2: A stamp converts to bins as coarse×99 + fine, where fine is below 99. A pulse whose falling bins minus rising bins is at least 1235 (the ceiling of 100 ns / 81 ps) is forwarded. A pulse narrower than that produces no output.
- R3: The forwarded stamp is the rising-edge coarse and fine value. `out_chan` carries the channel index 0..4, and stamps from one channel leave in the order they qualified.
- R4: A rising edge that arrives while a rising stamp is waiting replaces it, and that channel's overlap counter (bits [16c+15:16c] of `overlap_cnt`) increments. A later falling edge is measured against the newer stamp.
- R5: A falling edge with no waiting rising stamp produces no output and changes no counter.
- R6: A rising edge less than 1235 bins after the last accepted rising edge on its channel is refused. The waiting stamp is left unchanged, and the spacing counter (bits [16c+15:16c] of `space_cnt`) increments. A gap of exactly 1235 bins is accepted. The first rising edge after reset is always accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_chan`, `out_coarse` and `out_fine` hold their values.
- R8: After reset the arbiter starts its search at channel 0. After a transfer from channel c, the search starts at channel c+1, wrapping after channel 4.
- R9: Each channel buffers up to 2 qualified stamps. A stamp that qualifies while its channel's buffer already holds 2 is dropped, and that channel's bit of `skid_ovf` sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 5 | Edge event present, one bit per channel |
| ev_rise | input | 5 | 1 = rising edge, 0 = falling edge, per channel |
| ev_coarse | input | 160 | Coarse cycle count, channel c in bits [32c+31:32c] |
| ev_fine | input | 35 | Fine bin count, channel c in bits [7c+6:7c] |
| out_valid | output | 1 | Output stamp available |
| out_ready | input | 1 | Consumer takes the stamp this cycle |
| out_chan | output | 3 | Channel tag of the output stamp |
| out_coarse | output | 32 | Coarse part of the forwarded rising stamp |
| out_fine | output | 7 | Fine part of the forwarded rising stamp |
| overlap_cnt | output | 80 | Per-channel overlap counters, 16 bits each |
| space_cnt | output | 80 | Per-channel spacing-violation counters, 16 bits each |
| skid_ovf | output | 5 | Sticky per-channel buffer overflow flags |

## Verification
The hardest states to reach from the ports are a full channel buffer and a round-robin order that every channel contributes to. Both need several channels to qualify pulses while the consumer refuses data. A directed phase holds `out_ready` low and qualifies one pulse on every channel plus two more on channel 0. It then checks the drop, the sticky flag, the held output and the tag order 0,1,2,3,4,0 once the consumer accepts again. Randomized edge sequences then drive widths and gaps on both sides of the 1235-bin threshold, together with double rises and stray falls.

// File: rtl/pwq_pkg.sv
// Package pwq_pkg
// Shared elaboration-time helpers for the pulse-width qualifier.
// Assumes all time quantities are given in picoseconds as positive integers.
package pwq_pkg;

    // Rounded-up integer division, used to turn a picosecond limit into bins.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Rounded-to-nearest division, used for the bins contained in one clock cycle.
    function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/pwq_channel.sv
// Module pwq_channel
// Per-channel edge qualifier. Holds the latest accepted rising stamp,
// refuses rising edges that come too soon after the previous accepted one,
// and on a falling edge emits the waiting rising stamp for one cycle if the
// pulse was wide enough. Assumes at most one edge event per cycle and
// fine < BPC; bin arithmetic is modulo 2**TW.
module pwq_channel #(
    parameter int unsigned COARSE_W   = 32,
    parameter int unsigned FINE_W     = 7,
    parameter int unsigned TW         = 40,
    parameter int unsigned BPC        = 99,
    parameter int unsigned MIN_W_BINS = 1235,
    parameter int unsigned MIN_S_BINS = 1235,
    parameter int unsigned CNT_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic                ev_rise,
    input  logic [COARSE_W-1:0] ev_coarse,
    input  logic [FINE_W-1:0]   ev_fine,
    output logic                qual_valid,
    output logic [COARSE_W-1:0] qual_coarse,
    output logic [FINE_W-1:0]   qual_fine,
    output logic [CNT_W-1:0]    overlap_cnt,
    output logic [CNT_W-1:0]    space_cnt
);

    logic [TW-1:0]       ev_bins;
    logic [TW-1:0]       pend_bins;
    logic [TW-1:0]       last_bins;
    logic [COARSE_W-1:0] pend_coarse;
    logic [FINE_W-1:0]   pend_fine;
    logic                pend_v;
    logic                last_v;
    logic [TW-1:0]       rise_gap;
    logic [TW-1:0]       width;
    logic                space_ok;
    logic                wide_ok;

    // Convert the incoming stamp to a single bin count and form both differences.
    always_comb begin
        ev_bins  = TW'(ev_coarse) * TW'(BPC) + TW'(ev_fine);
        rise_gap = ev_bins - last_bins;
        width    = ev_bins - pend_bins;
        space_ok = !last_v || (rise_gap >= TW'(MIN_S_BINS));
        wide_ok  = width >= TW'(MIN_W_BINS);
    end

    // Track waiting stamp, spacing history and counters; emit qualified stamps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v      <= 1'b0;
            last_v      <= 1'b0;
            pend_bins   <= '0;
            last_bins   <= '0;
            pend_coarse <= '0;
            pend_fine   <= '0;
            qual_valid  <= 1'b0;
            qual_coarse <= '0;
            qual_fine   <= '0;
            overlap_cnt <= '0;
            space_cnt   <= '0;
        end else begin
            qual_valid <= 1'b0;
            if (ev_valid && ev_rise) begin
                if (space_ok) begin
                    if (pend_v) overlap_cnt <= overlap_cnt + 1'b1;
                    pend_v      <= 1'b1;
                    pend_bins   <= ev_bins;
                    pend_coarse <= ev_coarse;
                    pend_fine   <= ev_fine;
                    last_v      <= 1'b1;
                    last_bins   <= ev_bins;
                end else begin
                    space_cnt <= space_cnt + 1'b1;
                end
            end else if (ev_valid && pend_v) begin
                pend_v <= 1'b0;
                if (wide_ok) begin
                    qual_valid  <= 1'b1;
                    qual_coarse <= pend_coarse;
                    qual_fine   <= pend_fine;
                end
            end
        end
    end

    // R2
    qual_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_valid |-> $past(ev_valid && !ev_rise && pend_v));

    // R6
    space_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (space_cnt != $past(space_cnt)) |-> $past(ev_valid && ev_rise && last_v));

    // R4
    overlap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overlap_cnt != $past(overlap_cnt)) |-> $past(ev_valid && ev_rise && pend_v));

endmodule

// File: rtl/pwq_skid.sv
// Module pwq_skid
// Small per-channel queue for qualified stamps. A push that finds the
// queue full is dropped and sets a sticky overflow flag. Assumes pop is
// only meaningful when not empty; a pop on empty is ignored.
module pwq_skid #(
    parameter int unsigned W     = 39,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head,
    output logic         ovf
);

    localparam int unsigned PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CTW = $clog2(DEPTH + 1);

    logic [W-1:0]   mem [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [CTW-1:0] count;
    logic           full;
    logic           do_push;
    logic           do_pop;

    // Occupancy flags and accepted operations.
    always_comb begin
        full    = (count == CTW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Store accepted stamps; storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CTW'(do_push) - CTW'(do_pop);
            if (push && full) ovf <= 1'b1;
        end
    end

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CTW'(DEPTH));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/pwq_rr_arb.sv
// Module pwq_rr_arb
// Round-robin arbiter with grant hold. The search starts at the channel
// after the last one served; while the consumer stalls, the grant is frozen
// so the selected output stays stable. Assumes a requester stays asserted
// until it is served.
module pwq_rr_arb #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          ready,
    output logic          any,
    output logic [IW-1:0] grant
);

    logic [IW-1:0] ptr;
    logic [IW-1:0] pick;
    logic          hold_v;
    logic [IW-1:0] hold_idx;

    // Find the first requester at or after the pointer, wrapping around.
    always_comb begin
        logic found;
        int   idx;
        found = 1'b0;
        pick  = ptr;
        for (int i = 0; i < int'(N); i++) begin
            idx = (int'(ptr) + i) % int'(N);
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
        any   = |req;
        grant = hold_v ? hold_idx : pick;
    end

    // Advance the pointer on a transfer; freeze the grant on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            hold_v   <= 1'b0;
            hold_idx <= '0;
        end else begin
            hold_v   <= any && !ready;
            hold_idx <= grant;
            if (any && ready) ptr <= (grant == IW'(N - 1)) ? '0 : grant + 1'b1;
        end
    end

    // R8
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[grant]);

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any && !ready) |=> (any && grant == $past(grant)));

endmodule

// File: rtl/pulse_width_qualifier.sv
// Module pulse_width_qualifier
// Top level: one qualifier and one skid queue per channel, merged through
// a round-robin arbiter onto a tagged valid/ready stream. Assumes all
// channels share one time base and fine counts stay below the bins per cycle.
module pulse_width_qualifier #(
    parameter int unsigned NUM_CH       = 5,
    parameter int unsigned COARSE_W     = 32,
    parameter int unsigned FINE_W       = 7,
    parameter int unsigned TAG_W        = 3,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned SKID_DEPTH   = 2,
    parameter int unsigned CLK_PS       = 8000,
    parameter int unsigned BIN_PS       = 81,
    parameter int unsigned MIN_WIDTH_PS = 100000,
    parameter int unsigned MIN_SPACE_PS = 100000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          ev_valid,
    input  logic [NUM_CH-1:0]          ev_rise,
    input  logic [NUM_CH*COARSE_W-1:0] ev_coarse,
    input  logic [NUM_CH*FINE_W-1:0]   ev_fine,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [TAG_W-1:0]           out_chan,
    output logic [COARSE_W-1:0]        out_coarse,
    output logic [FINE_W-1:0]          out_fine,
    output logic [NUM_CH*CNT_W-1:0]    overlap_cnt,
    output logic [NUM_CH*CNT_W-1:0]    space_cnt,
    output logic [NUM_CH-1:0]          skid_ovf
);

    localparam int unsigned BPC        = pwq_pkg::round_div(CLK_PS, BIN_PS);
    localparam int unsigned MIN_W_BINS = pwq_pkg::ceil_div(MIN_WIDTH_PS, BIN_PS);
    localparam int unsigned MIN_S_BINS = pwq_pkg::ceil_div(MIN_SPACE_PS, BIN_PS);
    localparam int unsigned TW         = COARSE_W + FINE_W + 1;
    localparam int unsigned SW         = COARSE_W + FINE_W;

    logic [NUM_CH-1:0] q_valid;
    logic [NUM_CH-1:0] q_empty;
    logic [NUM_CH-1:0] q_pop;
    logic [SW-1:0]     q_data [NUM_CH];
    logic [SW-1:0]     q_head [NUM_CH];
    logic [TAG_W-1:0]  grant;
    logic              any;

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        logic [COARSE_W-1:0] qc;
        logic [FINE_W-1:0]   qf;

        pwq_channel #(
            .COARSE_W(COARSE_W), .FINE_W(FINE_W), .TW(TW), .BPC(BPC),
            .MIN_W_BINS(MIN_W_BINS), .MIN_S_BINS(MIN_S_BINS), .CNT_W(CNT_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_valid   (ev_valid[c]),
            .ev_rise    (ev_rise[c]),
            .ev_coarse  (ev_coarse[c*COARSE_W +: COARSE_W]),
            .ev_fine    (ev_fine[c*FINE_W +: FINE_W]),
            .qual_valid (q_valid[c]),
            .qual_coarse(qc),
            .qual_fine  (qf),
            .overlap_cnt(overlap_cnt[c*CNT_W +: CNT_W]),
            .space_cnt  (space_cnt[c*CNT_W +: CNT_W])
        );

        assign q_data[c] = {qc, qf};
        assign q_pop[c]  = any && out_ready && (grant == TAG_W'(c));

        pwq_skid #(.W(SW), .DEPTH(SKID_DEPTH)) u_skid (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (q_valid[c]),
            .push_data(q_data[c]),
            .pop      (q_pop[c]),
            .empty    (q_empty[c]),
            .head     (q_head[c]),
            .ovf      (skid_ovf[c])
        );
    end

    pwq_rr_arb #(.N(NUM_CH), .IW(TAG_W)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (~q_empty),
        .ready(out_ready),
        .any  (any),
        .grant(grant)
    );

    // Drive the merged output from the granted queue head.
    always_comb begin
        out_valid  = any;
        out_chan   = grant;
        out_coarse = q_head[grant][FINE_W +: COARSE_W];
        out_fine   = q_head[grant][FINE_W-1:0];
    end

    // R7
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chan)
                                       && $stable(out_coarse) && $stable(out_fine)));

    // R3
    out_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan < TAG_W'(NUM_CH)));

endmodule

// File: tb/pulse_width_qualifier_tb.sv
`timescale 1ns/1ps
module pulse_width_qualifier_tb;
    localparam int NCH  = 5;
    localparam int CW   = 32;
    localparam int FW   = 7;
    localparam int NB   = 99;
    localparam int MINB = (100000 + 81 - 1) / 81;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ev_valid = '0;
    logic [NCH-1:0]    ev_rise = '0;
    logic [NCH*CW-1:0] ev_coarse = '0;
    logic [NCH*FW-1:0] ev_fine = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [2:0]        out_chan;
    logic [CW-1:0]     out_coarse;
    logic [FW-1:0]     out_fine;
    logic [NCH*16-1:0] overlap_cnt;
    logic [NCH*16-1:0] space_cnt;
    logic [NCH-1:0]    skid_ovf;

    pulse_width_qualifier u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_rise(ev_rise),
        .ev_coarse(ev_coarse), .ev_fine(ev_fine), .out_valid(out_valid),
        .out_ready(out_ready), .out_chan(out_chan), .out_coarse(out_coarse),
        .out_fine(out_fine), .overlap_cnt(overlap_cnt), .space_cnt(space_cnt),
        .skid_ovf(skid_ovf)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int outcnt = 0;

    // model state
    bit              pv [NCH];
    longint          pend_b [NCH];
    bit              rv [NCH];
    longint          ref_b [NCH];
    int              exp_ov [NCH];
    int              exp_sp [NCH];
    logic [CW+FW-1:0] expq [NCH][$];
    longint          tnow [NCH];
    int              tag_log [$];
    bit              log_tags = 0;

    function automatic logic [CW+FW-1:0] stamp_of(longint b);
        logic [CW-1:0] c;
        logic [FW-1:0] f;
        c = CW'(b / NB);
        f = FW'(b % NB);
        return {c, f};
    endfunction

    task automatic chk(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            pv[c] = 0; rv[c] = 0; pend_b[c] = 0; ref_b[c] = 0;
            exp_ov[c] = 0; exp_sp[c] = 0; expq[c].delete(); tnow[c] = 1000;
        end
    endtask

    // schedule one event on channel c for the coming edge and update the model
    task automatic put_event(int c, bit rise, longint b);
        logic [CW+FW-1:0] s;
        s = stamp_of(b);
        ev_valid[c] = 1'b1;
        ev_rise[c]  = rise;
        ev_coarse[c*CW +: CW] = s[CW+FW-1:FW];
        ev_fine[c*FW +: FW]   = s[FW-1:0];
        if (rise) begin
            if (rv[c] && (b - ref_b[c]) < MINB) exp_sp[c]++;
            else begin
                if (pv[c]) exp_ov[c]++;
                pv[c] = 1; pend_b[c] = b; rv[c] = 1; ref_b[c] = b;
            end
        end else if (pv[c]) begin
            pv[c] = 0;
            if (b - pend_b[c] >= MINB) expq[c].push_back(stamp_of(pend_b[c]));
        end
    endtask

    task automatic check_out();
        int ch;
        ch = int'(out_chan);
        if (ch >= NCH) begin
            chk(0, "R3 tag", ch, 0);
        end else if (expq[ch].size() == 0) begin
            chk(0, "R3 unexpected stamp", ch, -1);
        end else begin
            chk({out_coarse, out_fine} == expq[ch][0], "R3 stamp",
                longint'({out_coarse, out_fine}), longint'(expq[ch][0]));
            void'(expq[ch].pop_front());
        end
        outcnt++;
        if (log_tags) tag_log.push_back(ch);
    endtask

    // one clock: check any transfer, advance, clear events
    task automatic step();
        if (out_valid && out_ready) check_out();
        @(posedge clk);
        @(negedge clk);
        ev_valid = '0;
    endtask

    task automatic drain(int n);
        out_ready = 1'b1;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ev_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic check_counters(string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(overlap_cnt[c*16 +: 16] == 16'(exp_ov[c]), {tag, " R4 overlap count"},
                overlap_cnt[c*16 +: 16], exp_ov[c]);
            chk(space_cnt[c*16 +: 16] == 16'(exp_sp[c]), {tag, " R6 spacing count"},
                space_cnt[c*16 +: 16], exp_sp[c]);
            chk(expq[c].size() == 0, {tag, " R2 missing stamps"}, expq[c].size(), 0);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int o0;
        logic [2:0] hold_c;
        logic [CW+FW-1:0] hold_d;
        int nxt [NCH];
        void'($urandom(1234));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(overlap_cnt == '0 && space_cnt == '0, "R1 counters", overlap_cnt[15:0], 0);
        chk(skid_ovf == '0, "R1 overflow", skid_ovf, 0);

        // R2 exact threshold passes, one bin less fails
        o0 = outcnt;
        put_event(1, 1, 5000); step();
        put_event(1, 0, 5000 + MINB); step();
        drain(6);
        chk(outcnt == o0 + 1, "R2 width at threshold", outcnt - o0, 1);
        put_event(1, 1, 9000); step();
        put_event(1, 0, 9000 + MINB - 1); step();
        drain(6);
        chk(outcnt == o0 + 1, "R2 width below threshold", outcnt - o0, 1);

        // R4 double rise uses the newer stamp
        put_event(2, 1, 20000); step();
        put_event(2, 1, 22000); step();
        put_event(2, 0, 23500); step();
        drain(6);
        chk(overlap_cnt[2*16 +: 16] == 16'd1, "R4 overlap", overlap_cnt[2*16 +: 16], 1);

        // R5 stray fall on idle channel
        o0 = outcnt;
        put_event(3, 0, 30000); step();
        drain(6);
        chk(outcnt == o0, "R5 stray fall output", outcnt - o0, 0);
        chk(overlap_cnt[3*16 +: 16] == 0 && space_cnt[3*16 +: 16] == 0,
            "R5 stray fall counters", space_cnt[3*16 +: 16], 0);

        // R6 spacing: too close refused, exact gap accepted
        o0 = outcnt;
        put_event(4, 1, 40000); step();
        put_event(4, 0, 40200); step();
        put_event(4, 1, 40000 + MINB - 1); step();
        put_event(4, 0, 40000 + 3000); step();
        drain(6);
        chk(space_cnt[4*16 +: 16] == 16'd1, "R6 refused rise", space_cnt[4*16 +: 16], 1);
        chk(outcnt == o0, "R6 refused rise no output", outcnt - o0, 0);
        put_event(4, 1, 50000); step();
        put_event(4, 0, 50200); step();
        put_event(4, 1, 50000 + MINB); step();
        put_event(4, 0, 50000 + 2 * MINB); step();
        drain(6);
        chk(outcnt == o0 + 1, "R6 exact gap accepted", outcnt - o0, 1);
        check_counters("directed");

        // R7 R8 R9 under back-pressure
        do_reset();
        out_ready = 1'b0;
        for (int c = 0; c < NCH; c++) put_event(c, 1, 100000);
        step();
        for (int c = 0; c < NCH; c++) put_event(c, 0, 101300);
        step();
        put_event(0, 1, 103000); step();
        put_event(0, 0, 104300); step();
        put_event(0, 1, 106000); step();
        put_event(0, 0, 107300); step();
        void'(expq[0].pop_back());
        step(); step();
        chk(skid_ovf == 5'b00001, "R9 overflow flag", skid_ovf, 1);
        chk(out_valid == 1'b1, "R7 valid under stall", out_valid, 1);
        hold_c = out_chan;
        hold_d = {out_coarse, out_fine};
        step(); step(); step();
        chk(out_valid && out_chan == hold_c && {out_coarse, out_fine} == hold_d,
            "R7 held output", out_chan, hold_c);
        tag_log.delete();
        log_tags = 1;
        drain(10);
        log_tags = 0;
        chk(tag_log.size() == 6, "R9 two kept on channel 0", tag_log.size(), 6);
        for (int i = 0; i < 6 && i < tag_log.size(); i++)
            chk(tag_log[i] == (i % NCH), "R8 round-robin order", tag_log[i], i % NCH);
        chk(skid_ovf == 5'b00001, "R9 flag sticky", skid_ovf, 1);
        check_counters("backpressure");

        // R1 reset clears the sticky flag
        do_reset();
        chk(skid_ovf == '0 && !out_valid, "R1 reset clears", skid_ovf, 0);

        // random phase
        for (int c = 0; c < NCH; c++) nxt[c] = c;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            out_ready = ($urandom % 8) != 0;
            for (int c = 0; c < NCH; c++) begin
                if (cyc >= nxt[c]) begin
                    int r;
                    r = $urandom % 100;
                    if (pv[c]) begin
                        if (r < 85) begin
                            tnow[c] += 1100 + ($urandom % 300);
                            put_event(c, 0, tnow[c]);
                        end else begin
                            tnow[c] += 50 + ($urandom % 1500);
                            put_event(c, 1, tnow[c]);
                        end
                    end else begin
                        if (r < 85) begin
                            tnow[c] += 50 + ($urandom % 1500);
                            put_event(c, 1, tnow[c]);
                        end else begin
                            tnow[c] += 100 + ($urandom % 500);
                            put_event(c, 0, tnow[c]);
                        end
                    end
                    nxt[c] = cyc + 8 + int'($urandom % 8);
                end
            end
            step();
        end
        drain(40);
        check_counters("random");
        chk(skid_ovf == '0, "R9 no overflow when drained", skid_ovf, 0);
        chk(out_valid == 1'b0, "R3 stream empty", out_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule